// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel bus to a single 16-bit NOR flash device. It turns one request into the multi-cycle command script that the device needs. The request chooses one of five operations: return to read mode, read the identification codes, program one word, erase one sector, or erase the whole device. It carries a target word address and, for programming, a data word. The block then generates the chip-enable, write-enable and output-enable strobes, drives the address and write data, and samples the read data returned by the device.

Each script is a fixed list of steps. A write step performs one complete write-enable pulse. A toggle step reads the target word over and over until the busy bit (data bit 6, mask 0x0040) stops changing between two reads. A read-back step compares the word with the expected value and only raises a warning. A compare step ends the operation as a failure on a mismatch. Parameter cycle counts set the setup, pulse, hold and read-access times. A parameter limit bounds how long a toggle step may last.

Operation codes on `req_op` are 0 for return to read mode, 1 for identify, 2 for program, 3 for sector erase and 4 for chip erase.

Top module: `nfs_sequencer`

## Requirements
- R1: Operation 0 performs exactly one bus write of 0xF0 to word address 0. It then completes with warn, fail and tmo all low, and it performs no read.
- R2: Operations 1 to 4 begin with the writes 0xAA to address 0x555 and then 0x55 to address 0x2AA.
- R3: Program (2) continues with 0xA0 to 0x555 and then the request data to the target address, followed by a toggle step and a read-back at the target address. A read-back value that differs from the request data sets warn, leaves fail low, and the operation still completes.
- R4: Sector erase (3) continues with 0x80 to 0x555, a second unlock pair, and 0x30 to the target address, followed by a toggle step and a read-back that expects 0xFFFF. A differing value sets warn.
- R5: Chip erase (4) follows the same script as sector erase, except that its sixth write is 0x10 to 0x555.
- R6: Identify (1) writes 0x90 to 0x555. It compares the word at address 0 with MAKER_ID and then the word at address 1 with DEV_ID, and finally writes 0xF0 to address 0. On the first mismatch it stops at once with fail high: it makes no further read and does not perform the final write.
- R7: A toggle step reads only the target address. It moves on to the next step at the first read whose bit 6 equals bit 6 of the read just before it.
- R8: When a toggle step has seen TMO_LIMIT successive unequal pairs, which is TMO_LIMIT+1 reads, the operation ends with tmo and fail high. No read-back and no further write is made.
- R9: In a write cycle, chip-enable is low for T_SETUP cycles before write-enable falls. Write-enable then stays low for T_PULSE cycles and chip-enable stays low for T_HOLD cycles after it rises. Address and data are stable while write-enable is low.
- R10: In a read cycle, output-enable is low for T_ACC cycles. Output-enable and write-enable are never low together.
- R11: A request is taken only while busy is low. Busy is high from the cycle after acceptance until completion. A request made while busy is high has no effect.
- R12: Done is a one-cycle pulse with busy low. Warn, fail and tmo are valid with done, stay unchanged until the next accepted request, and are cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while busy is low |
| req_op | input | 3 | Operation code (0 to 4) |
| req_addr | input | ADDR_W | Target word address |
| req_data | input | 16 | Data word to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| warn | output | 1 | Read-back mismatch seen |
| fail | output | 1 | Compare mismatch or timeout |
| tmo | output | 1 | Toggle step exceeded its limit |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_addr | output | ADDR_W | Word address to the device |
| flash_dq_out | output | 16 | Write data to the device |
| flash_dq_oe | output | 1 | High while the block drives the data bus |
| flash_dq_in | input | 16 | Read data from the device |

## Verification
A behavioural device model answers the strobes. It recognises the unlock and command writes, and it flips bit 6 for a chosen number of reads after a program or erase. Busy lengths of 2 and 3 reads are combined with data words whose bit 6 is set or clear, so the exact read count tells an early exit from a late settle in the toggle step. A never-ending busy model separates the timeout path from a normal settle. Corrupted stored data, a sector that does not erase, and wrong manufacturer or device codes separate the non-fatal warning path from the fatal compare path. A request injected during an operation shows that busy masking works.

// File: rtl/nfs_pkg.sv
package nfs_pkg;

  typedef enum logic [2:0] {
    OP_RESET  = 3'd0,
    OP_IDENT  = 3'd1,
    OP_PROG   = 3'd2,
    OP_SERASE = 3'd3,
    OP_CERASE = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    SK_END, SK_WRITE, SK_TOGGLE, SK_READ, SK_CMP
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic        at_target;  // address comes from the request
    logic [11:0] addr;       // immediate word address
    logic        use_req;    // data comes from the request
    logic [15:0] data;       // immediate data / expected value
  } step_t;

  localparam int          STEP_W    = 4;
  localparam logic [15:0] BUSY_MASK = 16'h0040;

  function automatic step_t mk(kind_e k, logic tgt, logic [11:0] a,
                               logic req, logic [15:0] d);
    step_t s;
    s.kind = k; s.at_target = tgt; s.addr = a; s.use_req = req; s.data = d;
    return s;
  endfunction

  function automatic step_t wr(logic [11:0] a, logic [15:0] d);
    return mk(SK_WRITE, 1'b0, a, 1'b0, d);
  endfunction

  // Shared first part of both erase scripts (steps 0..4)
  function automatic step_t erase_head(logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      4'd0, 4'd3: s = wr(12'h555, 16'h00AA);
      4'd1, 4'd4: s = wr(12'h2AA, 16'h0055);
      4'd2:       s = wr(12'h555, 16'h0080);
      default:    s = mk(SK_END, 1'b0, 12'h0, 1'b0, 16'h0);
    endcase
    return s;
  endfunction

  function automatic step_t script_step(op_e op, logic [STEP_W-1:0] idx,
                                        logic [15:0] maker, logic [15:0] dev);
    step_t s;
    s = mk(SK_END, 1'b0, 12'h0, 1'b0, 16'h0);
    case (op)
      OP_RESET:
        if (idx == 4'd0) s = wr(12'h000, 16'h00F0);
      OP_IDENT:
        case (idx)
          4'd0: s = wr(12'h555, 16'h00AA);
          4'd1: s = wr(12'h2AA, 16'h0055);
          4'd2: s = wr(12'h555, 16'h0090);
          4'd3: s = mk(SK_CMP, 1'b0, 12'h000, 1'b0, maker);
          4'd4: s = mk(SK_CMP, 1'b0, 12'h001, 1'b0, dev);
          4'd5: s = wr(12'h000, 16'h00F0);
          default: ;
        endcase
      OP_PROG:
        case (idx)
          4'd0: s = wr(12'h555, 16'h00AA);
          4'd1: s = wr(12'h2AA, 16'h0055);
          4'd2: s = wr(12'h555, 16'h00A0);
          4'd3: s = mk(SK_WRITE,  1'b1, 12'h0, 1'b1, 16'h0);
          4'd4: s = mk(SK_TOGGLE, 1'b1, 12'h0, 1'b0, BUSY_MASK);
          4'd5: s = mk(SK_READ,   1'b1, 12'h0, 1'b1, 16'h0);
          default: ;
        endcase
      OP_SERASE, OP_CERASE:
        case (idx)
          4'd5: s = (op == OP_SERASE) ? mk(SK_WRITE, 1'b1, 12'h0, 1'b0, 16'h0030)
                                      : wr(12'h555, 16'h0010);
          4'd6: s = mk(SK_TOGGLE, 1'b1, 12'h0, 1'b0, BUSY_MASK);
          4'd7: s = mk(SK_READ,   1'b1, 12'h0, 1'b0, 16'hFFFF);
          default: s = erase_head(idx);
        endcase
      default: ;
    endcase
    return s;
  endfunction

  // Two successive busy-bit samples agree
  function automatic logic busy_settled(logic [15:0] a, logic [15:0] b);
    return ((a ^ b) & BUSY_MASK) == 16'h0;
  endfunction

endpackage

// File: rtl/nfs_script.sv
module nfs_script
  import nfs_pkg::*;
#(
  parameter logic [15:0] MAKER_ID = 16'h0001,
  parameter logic [15:0] DEV_ID   = 16'h2249
) (
  input  op_e               op,
  input  logic [STEP_W-1:0] idx,
  output step_t             step
);
  assign step = script_step(op, idx, MAKER_ID, DEV_ID);
endmodule

// File: rtl/nfs_bus.sv
module nfs_bus #(
  parameter int ADDR_W  = 20,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 3,
  parameter int T_HOLD  = 1,
  parameter int T_ACC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic              done,
  output logic [15:0]       rdata,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       dq_o,
  input  logic [15:0]       din
);
  localparam int TMAX1 = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TMAX2 = (T_HOLD > T_ACC) ? T_HOLD : T_ACC;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CNT_W = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(T_PULSE - 1);
  localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(T_HOLD - 1);
  localparam logic [CNT_W-1:0] L_ACC   = CNT_W'(T_ACC - 1);

  typedef enum logic [2:0] {B_IDLE, B_SETUP, B_LOW, B_HOLD, B_READ} bst_e;
  bst_e             st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= B_IDLE; cnt <= '0; done <= 1'b0;
      addr_o <= '0; dq_o <= '0; rdata <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        B_IDLE: if (start) begin
          addr_o <= addr; dq_o <= wdata; cnt <= '0;
          st <= is_write ? B_SETUP : B_READ;
        end
        B_SETUP: if (cnt == L_SETUP) begin cnt <= '0; st <= B_LOW; end
                 else cnt <= cnt + 1'b1;
        B_LOW:   if (cnt == L_PULSE) begin cnt <= '0; st <= B_HOLD; end
                 else cnt <= cnt + 1'b1;
        B_HOLD:  if (cnt == L_HOLD) begin done <= 1'b1; st <= B_IDLE; end
                 else cnt <= cnt + 1'b1;
        B_READ:  if (cnt == L_ACC) begin
                   rdata <= din; done <= 1'b1; st <= B_IDLE;
                 end else cnt <= cnt + 1'b1;
        default: st <= B_IDLE;
      endcase
    end
  end

  assign ce_n  = (st == B_IDLE);
  assign we_n  = (st != B_LOW);
  assign oe_n  = (st != B_READ);
  assign dq_oe = (st == B_SETUP) || (st == B_LOW) || (st == B_HOLD);
endmodule

// File: rtl/nfs_sequencer.sv
module nfs_sequencer
  import nfs_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          T_SETUP   = 2,
  parameter int          T_PULSE   = 3,
  parameter int          T_HOLD    = 1,
  parameter int          T_ACC     = 3,
  parameter int          TMO_LIMIT = 1024,
  parameter logic [15:0] MAKER_ID  = 16'h0001,
  parameter logic [15:0] DEV_ID    = 16'h2249
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_data,
  output logic              busy,
  output logic              done,
  output logic              warn,
  output logic              fail,
  output logic              tmo,
  output logic              flash_ce_n,
  output logic              flash_we_n,
  output logic              flash_oe_n,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [15:0]       flash_dq_out,
  output logic              flash_dq_oe,
  input  logic [15:0]       flash_dq_in
);
  localparam int TMO_W = $clog2(TMO_LIMIT + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_LIMIT - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_e;
  st_e               st;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;
  logic [STEP_W-1:0] step_q;
  logic              tog_have;
  logic [15:0]       tog_prev;
  logic [TMO_W-1:0]  tmo_cnt;
  step_t             cur;

  // Named internal events
  wire               accept;
  wire               bus_start;
  wire               bus_done;
  wire  [15:0]       bus_rdata;
  wire  [ADDR_W-1:0] step_addr;
  wire  [15:0]       step_data;
  wire               rd_mismatch;
  wire               tog_equal;
  wire               tmo_hit;

  nfs_script #(.MAKER_ID(MAKER_ID), .DEV_ID(DEV_ID)) u_script (
    .op(op_q), .idx(step_q), .step(cur)
  );

  assign accept      = req_valid && !busy;
  assign bus_start   = (st == S_ISSUE) && (cur.kind != SK_END);
  assign step_addr   = cur.at_target ? addr_q : ADDR_W'(cur.addr);
  assign step_data   = cur.use_req ? data_q : cur.data;
  assign rd_mismatch = (bus_rdata != step_data);
  assign tog_equal   = busy_settled(bus_rdata, tog_prev);
  assign tmo_hit     = (tmo_cnt == TMO_LAST);

  nfs_bus #(
    .ADDR_W(ADDR_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
    .T_HOLD(T_HOLD), .T_ACC(T_ACC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start),
    .is_write(cur.kind == SK_WRITE), .addr(step_addr), .wdata(step_data),
    .done(bus_done), .rdata(bus_rdata),
    .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n),
    .dq_oe(flash_dq_oe), .addr_o(flash_addr), .dq_o(flash_dq_out),
    .din(flash_dq_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_RESET; addr_q <= '0; data_q <= '0;
      step_q <= '0; tog_have <= 1'b0; tog_prev <= '0; tmo_cnt <= '0;
      done <= 1'b0; warn <= 1'b0; fail <= 1'b0; tmo <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (accept) begin
          op_q <= op_e'(req_op); addr_q <= req_addr; data_q <= req_data;
          step_q <= '0; tog_have <= 1'b0; tmo_cnt <= '0;
          warn <= 1'b0; fail <= 1'b0; tmo <= 1'b0;
          st <= S_ISSUE;
        end
        S_ISSUE: if (cur.kind == SK_END) begin
          done <= 1'b1; st <= S_IDLE;
        end else st <= S_WAIT;
        S_WAIT: if (bus_done) begin
          st <= S_ISSUE;
          case (cur.kind)
            SK_WRITE: step_q <= step_q + 1'b1;
            SK_READ: begin
              if (rd_mismatch) warn <= 1'b1;
              step_q <= step_q + 1'b1;
            end
            SK_CMP: if (rd_mismatch) begin
              fail <= 1'b1; done <= 1'b1; st <= S_IDLE;
            end else step_q <= step_q + 1'b1;
            SK_TOGGLE: if (!tog_have) begin
              tog_have <= 1'b1; tog_prev <= bus_rdata;
            end else if (tog_equal) begin
              tog_have <= 1'b0; step_q <= step_q + 1'b1;
            end else if (tmo_hit) begin
              tmo <= 1'b1; fail <= 1'b1; done <= 1'b1; st <= S_IDLE;
            end else begin
              tmo_cnt <= tmo_cnt + 1'b1; tog_prev <= bus_rdata;
            end
            default: st <= S_IDLE;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
endmodule

// File: rtl/nfs_sequencer_chk.sv
module nfs_sequencer_chk #(
  parameter int ADDR_W  = 20,
  parameter int T_PULSE = 3,
  parameter int T_ACC   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              warn,
  input logic              fail,
  input logic              tmo,
  input logic              flash_ce_n,
  input logic              flash_we_n,
  input logic              flash_oe_n,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [15:0]       flash_dq_out,
  input logic              bus_start
);
  logic [15:0] we_run, oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0; oe_run <= '0;
    end else begin
      we_run <= flash_we_n ? 16'd0 : we_run + 16'd1;
      oe_run <= flash_oe_n ? 16'd0 : oe_run + 16'd1;
    end
  end

  // R9
  wr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && !$past(flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

  // R9
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_we_n) |-> (we_run == 16'(T_PULSE)));

  // R9
  ce_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n || !flash_oe_n) |-> !flash_ce_n);

  // R10
  oe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flash_oe_n) |-> (oe_run == 16'(T_ACC)));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_oe_n));

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |-> flash_ce_n);

  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !req_valid) |=> ($stable(warn) && $stable(fail) && $stable(tmo)));

  // R8
  tmo_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> fail);
endmodule

bind nfs_sequencer nfs_sequencer_chk #(
  .ADDR_W(ADDR_W), .T_PULSE(T_PULSE), .T_ACC(T_ACC)
) u_chk (.*);

// File: tb/nfs_sequencer_test.sv
module nfs_sequencer_test;
  localparam int T_SETUP = 2, T_PULSE = 3, T_HOLD = 1, T_ACC = 3, TMO = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic busy, done, warn, fail, tmo;
  logic flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
  logic [19:0] flash_addr;
  logic [15:0] flash_dq_out;
  logic [15:0] flash_dq_in = '0;

  always #5 clk = ~clk;

  nfs_sequencer #(.ADDR_W(20), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE),
                  .T_HOLD(T_HOLD), .T_ACC(T_ACC), .TMO_LIMIT(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
    .warn(warn), .fail(fail), .tmo(tmo), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n), .flash_addr(flash_addr),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in)
  );

  // ---------------- device model ----------------
  logic [15:0] mem [256];
  int wn, rn;
  logic [19:0] wa [64];
  logic [15:0] wd [64];
  logic [19:0] ra [64];
  logic [19:0] p1a, p2a;
  logic [15:0] p1d, p2d;
  bit id_mode, pgm_arm, ers_arm, tog, stuck_en;
  int busy_left, busy_knob, last_erase;
  logic [15:0] corrupt, maker_m, dev_m;
  logic [7:0] stuck_addr;
  bit we_p, oe_p;
  logic [19:0] addr_p;
  logic [15:0] dq_p;
  int we_cnt, oe_cnt, scnt, hcnt;
  bit in_hold;
  int bad_pulse, bad_acc, bad_setup, bad_hold, bad_stable, overlap, n_pulses;

  task automatic dev_write(input logic [19:0] a, input logic [15:0] d);
    bit unl;
    unl = (p2a == 20'h555 && p2d == 16'hAA && p1a == 20'h2AA && p1d == 16'h55);
    if (wn < 64) begin wa[wn] = a; wd[wn] = d; end
    wn++;
    if (pgm_arm) begin
      mem[a[7:0]] = d ^ corrupt; busy_left = busy_knob; tog = 0; pgm_arm = 0;
    end else if (unl && a == 20'h555 && d == 16'hA0) pgm_arm = 1;
    else if (unl && a == 20'h555 && d == 16'h80) ers_arm = 1;
    else if (unl && ers_arm && (d == 16'h30 || (a == 20'h555 && d == 16'h10))) begin
      for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
      if (stuck_en) mem[stuck_addr] = 16'h0F0F;
      last_erase = (d == 16'h30) ? 1 : 2;
      ers_arm = 0; busy_left = busy_knob; tog = 0;
    end else if (unl && a == 20'h555 && d == 16'h90) id_mode = 1;
    else if (d == 16'hF0) begin
      id_mode = 0; busy_left = 0; pgm_arm = 0; ers_arm = 0;
    end
    p2a = p1a; p2d = p1d; p1a = a; p1d = d;
  endtask

  function automatic logic [15:0] dev_read(input logic [19:0] a);
    logic [15:0] v;
    if (busy_left > 0) begin
      tog = ~tog; busy_left--; v = mem[a[7:0]]; v[6] = tog;
    end else if (id_mode && a == 20'h0) v = maker_m;
    else if (id_mode && a == 20'h1) v = dev_m;
    else v = mem[a[7:0]];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      we_p = 1; oe_p = 1; we_cnt = 0; oe_cnt = 0; scnt = 0; hcnt = 0; in_hold = 0;
    end else begin
      if (flash_ce_n) scnt = 0;
      if (we_p && !flash_we_n) begin
        if (scnt != T_SETUP) bad_setup++;
      end
      if (!flash_ce_n && flash_we_n) scnt++;
      if (in_hold) begin
        if (flash_ce_n) begin
          if (hcnt != T_HOLD) bad_hold++;
          in_hold = 0;
        end else hcnt++;
      end
      if (!flash_we_n) begin
        we_cnt++;
        if (!we_p && (flash_addr != addr_p || flash_dq_out != dq_p)) bad_stable++;
      end
      if (!we_p && flash_we_n) begin
        if (we_cnt != T_PULSE) bad_pulse++;
        we_cnt = 0; n_pulses++;
        in_hold = 1; hcnt = 1;
        dev_write(addr_p, dq_p);
      end
      if (!flash_oe_n && !flash_we_n) overlap++;
      if (!flash_oe_n) oe_cnt++;
      if (oe_p && !flash_oe_n) begin
        if (rn < 64) ra[rn] = flash_addr;
        rn++;
        flash_dq_in <= dev_read(flash_addr);
      end
      if (!oe_p && flash_oe_n) begin
        if (oe_cnt != T_ACC) bad_acc++;
        oe_cnt = 0;
      end
      we_p = flash_we_n; oe_p = flash_oe_n; addr_p = flash_addr; dq_p = flash_dq_out;
    end
  end

  // ---------------- bench bookkeeping ----------------
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_wr(input string req, input int idx,
                        input logic [19:0] a, input logic [15:0] d);
    chk(req, $sformatf("write %0d addr", idx), wa[idx], a);
    chk(req, $sformatf("write %0d data", idx), wd[idx], d);
  endtask

  task automatic start_op(input logic [2:0] op, input logic [19:0] a, input logic [15:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    wn = 0; rn = 0;
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int cyc = 0;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
    chk(req, "done seen", done, 1'b1);
  endtask

  task automatic run_op(input string req, input logic [2:0] op,
                        input logic [19:0] a, input logic [15:0] d);
    start_op(op, a, d);
    wait_done(req);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset_state;
    chk("R11", "busy after reset", busy, 1'b0);
    chk("R12", "done after reset", done, 1'b0);
    chk("R9", "strobes idle", {flash_ce_n, flash_we_n, flash_oe_n}, 3'b111);
  endtask

  task automatic t_read_mode;
    run_op("R1", 3'd0, 20'h12345, 16'h0);
    chk("R1", "write count", wn, 1);
    chk_wr("R1", 0, 20'h0, 16'hF0);
    chk("R1", "read count", rn, 0);
    chk("R1", "flags", {warn, fail, tmo}, 3'b000);
  endtask

  task automatic t_ident_ok;
    maker_m = 16'h0001; dev_m = 16'h2249;
    run_op("R6", 3'd1, 20'h0, 16'h0);
    chk("R6", "write count", wn, 4);
    chk_wr("R2", 0, 20'h555, 16'hAA);
    chk_wr("R2", 1, 20'h2AA, 16'h55);
    chk_wr("R6", 2, 20'h555, 16'h90);
    chk_wr("R6", 3, 20'h0, 16'hF0);
    chk("R6", "read count", rn, 2);
    chk("R6", "read addrs", {ra[0], ra[1]}, {20'h0, 20'h1});
    chk("R6", "fail", fail, 1'b0);
  endtask

  task automatic t_ident_bad;
    dev_m = 16'h22DA;
    run_op("R6", 3'd1, 20'h0, 16'h0);
    chk("R6", "bad device fail", fail, 1'b1);
    chk("R6", "bad device writes", wn, 3);
    chk("R6", "bad device reads", rn, 2);
    chk("R6", "bad device warn", warn, 1'b0);
    maker_m = 16'h00C2; dev_m = 16'h2249;
    run_op("R6", 3'd1, 20'h0, 16'h0);
    chk("R6", "bad maker fail", fail, 1'b1);
    chk("R6", "bad maker reads", rn, 1);
    maker_m = 16'h0001;
    run_op("R1", 3'd0, 20'h0, 16'h0);
  endtask

  task automatic t_program;
    bit addr_ok = 1;
    busy_knob = 3; corrupt = 16'h0;
    run_op("R3", 3'd2, 20'h12, 16'h5A5A);
    chk("R3", "write count", wn, 4);
    chk_wr("R2", 0, 20'h555, 16'hAA);
    chk_wr("R3", 2, 20'h555, 16'hA0);
    chk_wr("R3", 3, 20'h12, 16'h5A5A);
    chk("R7", "reads bit6 set", rn, 5);
    for (int i = 0; i < rn && i < 64; i++) if (ra[i] != 20'h12) addr_ok = 0;
    chk("R7", "reads at target only", addr_ok, 1'b1);
    chk("R3", "flags", {warn, fail, tmo}, 3'b000);
    chk("R3", "stored word", mem[8'h12], 16'h5A5A);
    run_op("R7", 3'd2, 20'h34, 16'h1234);
    chk("R7", "reads bit6 clear", rn, 6);
    chk("R3", "flags second", {warn, fail}, 2'b00);
  endtask

  task automatic t_program_warn;
    busy_knob = 3; corrupt = 16'h0001;
    run_op("R3", 3'd2, 20'h20, 16'hC3C3);
    chk("R3", "warn on bad read-back", {warn, fail}, 2'b10);
    @(negedge clk);
    chk("R12", "done single cycle", done, 1'b0);
    repeat (5) @(negedge clk);
    chk("R12", "warn held", warn, 1'b1);
    corrupt = 16'h0;
  endtask

  task automatic t_sector_erase;
    busy_knob = 2; stuck_en = 0; last_erase = 0;
    run_op("R4", 3'd3, 20'h40, 16'h0);
    chk("R12", "warn cleared by new request", warn, 1'b0);
    chk("R4", "write count", wn, 6);
    chk_wr("R2", 1, 20'h2AA, 16'h55);
    chk_wr("R4", 2, 20'h555, 16'h80);
    chk_wr("R4", 3, 20'h555, 16'hAA);
    chk_wr("R4", 4, 20'h2AA, 16'h55);
    chk_wr("R4", 5, 20'h40, 16'h30);
    chk("R4", "sector erase seen", last_erase, 1);
    chk("R7", "erase reads", rn, 5);
    stuck_en = 1; stuck_addr = 8'h40;
    run_op("R4", 3'd3, 20'h40, 16'h0);
    chk("R4", "warn on unerased word", {warn, fail}, 2'b10);
    stuck_en = 0;
  endtask

  task automatic t_chip_erase;
    busy_knob = 2; last_erase = 0;
    run_op("R5", 3'd4, 20'h7, 16'h0);
    chk("R5", "write count", wn, 6);
    chk_wr("R5", 2, 20'h555, 16'h80);
    chk_wr("R5", 5, 20'h555, 16'h10);
    chk("R5", "chip erase seen", last_erase, 2);
    chk("R5", "read-back addr", ra[4], 20'h7);
    chk("R5", "flags", {warn, fail, tmo}, 3'b000);
  endtask

  task automatic t_timeout;
    busy_knob = 1000;
    run_op("R8", 3'd2, 20'h55, 16'h0101);
    chk("R8", "tmo and fail", {tmo, fail}, 2'b11);
    chk("R8", "toggle reads", rn, TMO + 1);
    chk("R8", "no further writes", wn, 4);
    run_op("R12", 3'd0, 20'h0, 16'h0);
    chk("R12", "flags cleared", {tmo, fail}, 2'b00);
  endtask

  task automatic t_busy_ignore;
    busy_knob = 3; last_erase = 0;
    start_op(3'd2, 20'h66, 16'hBEEF);
    chk("R11", "busy after accept", busy, 1'b1);
    repeat (10) @(negedge clk);
    req_valid = 1; req_op = 3'd4; req_addr = 20'h0;
    @(negedge clk);
    req_valid = 0;
    wait_done("R11");
    chk("R11", "write count", wn, 4);
    chk_wr("R11", 3, 20'h66, 16'hBEEF);
    chk("R11", "read count", rn, 5);
    chk("R11", "no erase", last_erase, 0);
    repeat (40) @(negedge clk);
    chk("R11", "still idle", {busy, flash_ce_n}, 2'b01);
  endtask

  task automatic t_timing;
    chk("R9", "pulse width", bad_pulse, 0);
    chk("R9", "setup", bad_setup, 0);
    chk("R9", "hold", bad_hold, 0);
    chk("R9", "addr/data stable", bad_stable, 0);
    chk("R9", "pulses seen", n_pulses > 20, 1'b1);
    chk("R10", "access width", bad_acc, 0);
    chk("R10", "strobe overlap", overlap, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37);
    busy_knob = 0; corrupt = 0; maker_m = 16'h0001; dev_m = 16'h2249;
    stuck_en = 0; stuck_addr = 0; last_erase = 0; busy_left = 0;
    p1a = 0; p2a = 0; p1d = 0; p2d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_read_mode();
    t_ident_ok();
    t_ident_bad();
    t_program();
    t_program_warn();
    t_sector_erase();
    t_chip_erase();
    t_timeout();
    t_busy_ignore();
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule